// File: doc/BRIEF.md
# Resonant Two-Pole Low-Pass Filter

This block applies a per-voice recursive two-pole low-pass filter to a stream of 16-bit signed samples. The cutoff arrives as a 13-bit code made of a 5-bit exponent and an 8-bit mantissa, which the block expands into a linear coefficient. A 5-bit resonance index selects a feedback weight from a fixed curve. The curve rises in even steps over most of its range and in doubled steps over the last three entries. The filter keeps its two most recent outputs as history.

Each input sample is qualified by a one-cycle valid strobe, and the filtered result appears one clock later with its own valid flag. A bypass control passes samples through untouched. A history-clear input lets the voice logic restart the recursion from silence, for example when a note's envelope restarts at attack. Generating the cutoff code over time and mixing the voices belong to other blocks.

Top module: `reso_lowpass`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: After reset, `out_valid` is 0, `out_sample` is 0 and both history registers are 0, so the first filtered output uses zero history.
- R3: The coefficient is f = ({1, cutoff[7:0]} << 4) >> (cutoff[12:8] XOR 31). The exponent is `cutoff[12:8]` and the mantissa is `cutoff[7:0]`.
- R4: When filtering is on, the output is y = (f*x + (8192 - f + q)*y1 - q*y2) >>> 13. The arithmetic uses 32-bit signed values and an arithmetic shift, and the result is saturated to -32768..32767.
- R5: After each filtered output, the older history takes the previous newer history, and the newer history takes the saturated output.
- R6: For resonance index i, q = 0x0E00 + i*0x80 when i <= 28, and q = 0x1C00 + (i-28)*0x100 when i is 29 to 31.
- R7: With `filt_en` low, a valid sample appears unchanged on `out_sample`, and the history is left as it was.
- R8: `hist_clr` high zeroes both history values. A valid sample in the same cycle is filtered as if the history were zero, and its output then becomes the newer history.
- R9: `out_sample` holds its value in the cycle after a cycle without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| cutoff | input | 13 | Cutoff code: exponent [12:8], mantissa [7:0] |
| reso | input | 5 | Resonance index |
| filt_en | input | 1 | 1 = filter, 0 = pass through |
| hist_clr | input | 1 | Zero the output history |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed filtered sample |

## Verification
The assertions check on every cycle the one-clock valid latency, the output hold between samples, the bypass path, history shifting and history clearing. The numeric result of the recursion cannot be checked by an assertion. This covers the coefficient decode, the resonance curve including its coarse top steps, and saturation under strong resonance. Only the bench's reference model can show these, by comparing each output against an independently computed value across sweeps of cutoff exponent, resonance index and signal level.

// File: rtl/reso_lowpass.sv
`timescale 1ns/1ps
module reso_lowpass #(
  parameter int SW   = 16,
  parameter int FRAC = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  input  logic [12:0]          cutoff,
  input  logic [4:0]           reso,
  input  logic                 filt_en,
  input  logic                 hist_clr,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_sample
);
  localparam logic signed [31:0] UNITY = 32'sd1 <<< FRAC;
  localparam logic signed [31:0] SMAX  = (32'sd1 <<< (SW-1)) - 32'sd1;
  localparam logic signed [31:0] SMIN  = -(32'sd1 <<< (SW-1));

  logic signed [SW-1:0] y1, y2;

  wire [4:0]  shamt = cutoff[12:8] ^ 5'h1F;
  wire [31:0] mant  = {19'd0, 1'b1, cutoff[7:0], 4'd0};
  wire signed [31:0] f = signed'(mant >> shamt);

  wire [4:0]  rtop = reso - 5'd28;
  wire [31:0] qraw = (reso <= 5'd28) ? (32'h0E00 + {20'd0, reso, 7'd0})
                                     : (32'h1C00 + {19'd0, rtop, 8'd0});
  wire signed [31:0] q = signed'(qraw);

  wire signed [31:0] xs = 32'(in_sample);
  wire signed [31:0] h1 = hist_clr ? 32'sd0 : 32'(y1);
  wire signed [31:0] h2 = hist_clr ? 32'sd0 : 32'(y2);

  wire signed [31:0] acc = f * xs + (UNITY - f + q) * h1 - q * h2;
  wire signed [31:0] shr = acc >>> FRAC;

  logic signed [SW-1:0] ysat;
  always_comb begin
    if (shr > SMAX)      ysat = SMAX[SW-1:0];
    else if (shr < SMIN) ysat = SMIN[SW-1:0];
    else                 ysat = shr[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      y1 <= '0;
      y2 <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_sample <= filt_en ? ysat : in_sample;
      if (in_valid && filt_en) begin
        y2 <= h1[SW-1:0];
        y1 <= ysat;
      end else if (hist_clr) begin
        y1 <= '0;
        y2 <= '0;
      end
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !filt_en) |=> out_sample == $past(in_sample));
  a_r7_hist_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !filt_en && !hist_clr) |=> ($stable(y1) && $stable(y2)));
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_en && !hist_clr) |=> (y2 == $past(y1) && y1 == out_sample));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_clr && !(in_valid && filt_en)) |=> (y1 == '0 && y2 == '0));
  a_r8_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_clr && in_valid && filt_en) |=> (y2 == '0 && y1 == out_sample));
endmodule

// File: tb/reso_lowpass_tb.sv
`timescale 1ns/1ps
module reso_lowpass_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic [12:0] cutoff = '0;
  logic [4:0] reso = '0;
  logic filt_en = 1'b0;
  logic hist_clr = 1'b0;
  logic out_valid;
  logic signed [15:0] out_sample;

  always #10 clk = ~clk;

  reso_lowpass u_dut (.*);

  int checks = 0, errors = 0;
  int m_y1 = 0, m_y2 = 0, exp_out = 0;
  bit exp_valid = 1'b0;
  string tag = "R2";
  bit done = 1'b0;

  function automatic int qval(int i);
    if (i <= 28) return 'h0E00 + i * 'h80;
    return 'h1C00 + (i - 28) * 'h100;
  endfunction

  function automatic int fval(int c);
    int m = (c & 255) | 256;
    int e = ((c >> 8) & 31) ^ 31;
    return (m << 4) >> e;
  endfunction

  function automatic int filt(int x, int c, int r, int a, int b);
    int f = fval(c);
    int q = qval(r);
    int s = (f * x + (8192 - f + q) * a - q * b) >>> 13;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s out_valid actual %0b expected %0b", tag, out_valid, exp_valid);
    end
    checks++;
    if (int'(out_sample) !== exp_out) begin
      errors++;
      $display("FAIL %s out_sample actual %0d expected %0d", tag, out_sample, exp_out);
    end
  endtask

  task automatic step(bit v, int x, int c, int r, bit en, bit clr);
    @(negedge clk);
    compare();
    in_valid = v; in_sample = 16'(x); cutoff = 13'(c); reso = 5'(r);
    filt_en = en; hist_clr = clr;
    exp_valid = v;
    if (clr) begin m_y1 = 0; m_y2 = 0; end
    if (v) begin
      if (en) begin
        int y = filt(x, c, r, m_y1, m_y2);
        m_y2 = m_y1; m_y1 = y; exp_out = y;
      end else exp_out = x;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R2";
    compare();
    rst_n = 1'b1;
    // R2: first filtered sample with reset history
    step(1, 12000, 'h1A80, 3, 1, 0);
    // R1 / R9: gaps between samples
    tag = "R1";
    step(0, 555, 'h1A80, 3, 1, 0);
    step(0, -5, 'h1A80, 3, 1, 0);
    tag = "R9";
    step(1, -7000, 'h1A80, 3, 1, 0);
    step(0, 1234, 'h0000, 31, 1, 0);
    step(0, 1234, 'h0000, 31, 1, 0);
    // R3: sweep exponent and mantissa
    tag = "R3";
    for (int e = 0; e < 32; e++)
      for (int mm = 0; mm < 256; mm += 85)
        step(1, (e * 997 + mm * 31) % 30000 - 15000, (e << 8) | mm, 10, 1, 0);
    // R6: every resonance index, including the coarse top entries
    tag = "R6";
    for (int r = 0; r < 32; r++) begin
      step(1, 0, 'h1FFF, r, 1, 1);
      step(1, 20000, 'h1C40, r, 1, 0);
      step(1, -20000, 'h1C40, r, 1, 0);
      step(1, 0, 'h1C40, r, 1, 0);
    end
    // R4: saturation under strong resonance and full-scale input
    tag = "R4";
    step(1, 0, 'h1FFF, 31, 1, 1);
    for (int i = 0; i < 40; i++)
      step(1, (i % 8 < 4) ? 32767 : -32768, 'h1F00 + i, 31, 1, 0);
    // R5: history shifting on a step input
    tag = "R5";
    for (int i = 0; i < 30; i++) step(1, 25000, 'h1800, 16, 1, 0);
    // R7: bypass leaves history alone; resume continues recursion
    tag = "R7";
    step(1, 321, 'h1800, 16, 0, 0);
    step(1, -32768, 'h1800, 16, 0, 0);
    step(1, 25000, 'h1800, 16, 1, 0);
    // R8: clear alone, then clear with a sample
    tag = "R8";
    step(1, 30000, 'h1E00, 20, 1, 0);
    step(0, 0, 'h1E00, 20, 1, 1);
    step(1, 30000, 'h1E00, 20, 1, 0);
    step(1, 30000, 'h1E00, 20, 1, 1);
    step(1, 30000, 'h1E00, 20, 1, 0);
    step(1, 100, 'h1E00, 20, 0, 1);
    step(1, -9000, 'h1E00, 20, 1, 0);
    // mixed traffic
    tag = "R4";
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, int'($urandom % 65536) - 32768, int'($urandom % 8192),
           int'($urandom % 32), ($urandom % 8) != 0, ($urandom % 32) == 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule